// File: doc/BRIEF.md
# Shadowed 8/16-bit Timer/Counter

This block is a timer/counter that sits on an 8-bit register bus. It counts either an internal tick enable or rising edges of an external input that is brought into the clock domain through a synchronizer. It can run as an 8-bit counter or as a 16-bit counter. Each wrap to zero sets a sticky overflow flag. A registered interrupt request is driven from that flag, gated by an enable bit.

The upper byte of the counter is never visible on the bus. Reading the low byte captures the live upper byte into a holding register. Writing the low byte loads the holding register into the upper byte together with the new low byte. Software can therefore read or load all 16 bits as one coherent value, even while the counter runs between the two byte accesses.

Bus map (2-bit address): 0 is the counter low byte, 1 is the upper-byte holding register, 2 is the control/status byte (bit 0 flag, bit 1 interrupt enable, other bits read as zero), and 3 reads as zero. Reads are registered: `rd_data` shows the value on the clock edge that follows the cycle in which `rd_stb` was high.

Top module: `shadow_timer`

## Requirements
- R1: After reset the counter, holding register, flag, enable, `irq` and `rd_data` are all zero.
- R2: With `ext_sel` low, the counter advances by one on each clock edge where `int_tick` is high, and holds its value when `int_tick` is low.
- R3: With `ext_sel` high, `int_tick` is ignored and each rising edge of `ext_clk` advances the counter exactly once, after a two-flop synchronizer and an edge detector. A long high level counts only once.
- R4: In 16-bit mode (`mode_16`=1) an increment from 0xFFFF to 0x0000 sets the flag. In 8-bit mode an increment of the low byte from 0xFF to 0x00 sets the flag.
- R5: The flag stays set until software writes 0 to bit 0 at address 2. If an overflow happens in the same cycle as that write, the flag stays set.
- R6: `irq` is the AND of flag and enable (bit 1 at address 2), delayed by one register stage.
- R7: A read of address 0 returns the low byte. In the same cycle it copies the live upper byte into the holding register.
- R8: A read of address 1 returns the holding register. It does not return the live upper byte, so the value stays consistent with the last low-byte read even after a rollover.
- R9: A write to address 1 changes only the holding register. The counter is not modified.
- R10: A write to address 0 loads the counter with {holding register, data} in one cycle and takes priority over an increment in that cycle. Counting then resumes from the written value.
- R11: In 8-bit mode the upper byte of the counter is held at zero, including after low-byte writes. A low-byte read therefore leaves zero in the holding register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 2 | Register address |
| wr_stb | input | 1 | Write strobe |
| rd_stb | input | 1 | Read strobe |
| wr_data | input | BYTE_W | Write data |
| rd_data | output | BYTE_W | Registered read data |
| mode_16 | input | 1 | 1 selects 16-bit counting, 0 selects 8-bit counting |
| ext_sel | input | 1 | 1 counts external edges, 0 counts the internal tick |
| int_tick | input | 1 | Internal count enable |
| ext_clk | input | 1 | Asynchronous external count input |
| irq | output | 1 | Registered gated interrupt request |

## Verification
The assertions check on every cycle that an overflow always leaves the flag set, and that the flag cannot drop without a control write. They also check that `irq` follows flag and enable one cycle later, that the upper byte stays zero in 8-bit mode, that a low-byte write commits the held byte, and that the holding register changes only on its two bus events. The edge detector is also checked to emit single-cycle pulses. Some behaviour can only be seen in the bench's scenarios, which compare every bus read against a queue of expected values. These are the coherence of a split 16-bit read across a rollover, the count of external edges, write priority over a tick, and the clear-versus-overflow collision.

// File: rtl/shadow_timer_pkg.sv
package shadow_timer_pkg;

   typedef enum logic [1:0] {
      ADDR_LO   = 2'd0,
      ADDR_HBUF = 2'd1,
      ADDR_CTRL = 2'd2,
      ADDR_RSVD = 2'd3
   } st_addr_e;

   localparam int CTRL_FLAG_BIT = 0;
   localparam int CTRL_EN_BIT   = 1;

endpackage

// File: rtl/st_edge_sync.sv
module st_edge_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   output logic rise_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("st_edge_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;
   logic              prev_q;

   for (genvar i = 0; i < STAGES; i++) begin : g_chain
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[0] <= 1'b0;
            else        chain_q[0] <= async_in;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[i] <= 1'b0;
            else        chain_q[i] <= chain_q[i-1];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= chain_q[STAGES-1];
   end

   assign rise_o = chain_q[STAGES-1] & ~prev_q;

   // R3: one detected edge is a single-cycle pulse
   p_single_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
      rise_o |=> !rise_o);

endmodule

// File: rtl/st_count_core.sv
module st_count_core #(
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mode_16,
   input  logic              tick,
   input  logic              wr_lo,
   input  logic              wr_ctrl,
   input  logic [BYTE_W-1:0] wdata,
   input  logic [BYTE_W-1:0] hbuf,
   output logic [BYTE_W-1:0] cnt_lo,
   output logic [BYTE_W-1:0] cnt_hi,
   output logic              flag,
   output logic              irq_en,
   output logic              irq
);
   import shadow_timer_pkg::*;

   localparam int CNT_W = 2 * BYTE_W;

   if (BYTE_W < 2) begin : g_bad_width
      $error("st_count_core: BYTE_W must be at least 2");
   end

   logic [CNT_W-1:0] cnt_next16;
   logic             lo_full;
   logic             hi_full;
   logic             ovf;

   assign cnt_next16 = {cnt_hi, cnt_lo} + 1'b1;
   assign lo_full    = &cnt_lo;
   assign hi_full    = &cnt_hi;
   assign ovf        = tick & ~wr_lo & lo_full & (hi_full | ~mode_16);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_lo <= '0;
         cnt_hi <= '0;
      end else if (wr_lo) begin
         cnt_lo <= wdata;
         cnt_hi <= mode_16 ? hbuf : '0;
      end else if (tick) begin
         cnt_lo <= cnt_next16[BYTE_W-1:0];
         cnt_hi <= mode_16 ? cnt_next16[CNT_W-1:BYTE_W] : '0;
      end else if (!mode_16) begin
         cnt_hi <= '0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag   <= 1'b0;
         irq_en <= 1'b0;
         irq    <= 1'b0;
      end else begin
         if (ovf)          flag <= 1'b1;
         else if (wr_ctrl) flag <= wdata[CTRL_FLAG_BIT];
         if (wr_ctrl)      irq_en <= wdata[CTRL_EN_BIT];
         irq <= flag & irq_en;
      end
   end

   p_ovf_sets_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ovf |=> flag);
   p_flag_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (flag && !wr_ctrl) |=> flag);
   p_irq_masked_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_en |=> !irq);
   p_irq_follows_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (flag && irq_en) |=> irq);
   p_hi_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !mode_16 |=> (cnt_hi == '0));
   p_write_commit_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_lo && mode_16) |=> ({cnt_hi, cnt_lo} == {$past(hbuf), $past(wdata)}));

endmodule

// File: rtl/st_bus_regs.sv
module st_bus_regs #(
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        addr,
   input  logic              wr_stb,
   input  logic              rd_stb,
   input  logic [BYTE_W-1:0] wr_data,
   input  logic              mode_16,
   input  logic [BYTE_W-1:0] cnt_lo,
   input  logic [BYTE_W-1:0] cnt_hi,
   input  logic              flag,
   input  logic              irq_en,
   output logic [BYTE_W-1:0] hbuf,
   output logic              wr_lo,
   output logic              wr_ctrl,
   output logic [BYTE_W-1:0] rd_data
);
   import shadow_timer_pkg::*;

   st_addr_e    sel;
   logic        rd_lo;
   logic        wr_hbuf;
   logic [BYTE_W-1:0] ctrl_view;
   logic [BYTE_W-1:0] rd_mux;

   assign sel     = st_addr_e'(addr);
   assign rd_lo   = rd_stb & (sel == ADDR_LO);
   assign wr_lo   = wr_stb & (sel == ADDR_LO);
   assign wr_hbuf = wr_stb & (sel == ADDR_HBUF);
   assign wr_ctrl = wr_stb & (sel == ADDR_CTRL);

   always_comb begin
      ctrl_view = '0;
      ctrl_view[CTRL_FLAG_BIT] = flag;
      ctrl_view[CTRL_EN_BIT]   = irq_en;
   end

   always_comb begin
      unique case (sel)
         ADDR_LO:   rd_mux = cnt_lo;
         ADDR_HBUF: rd_mux = hbuf;
         ADDR_CTRL: rd_mux = ctrl_view;
         default:   rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       hbuf <= '0;
      else if (rd_lo)   hbuf <= mode_16 ? cnt_hi : '0;
      else if (wr_hbuf) hbuf <= wr_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      rd_data <= '0;
      else if (rd_stb) rd_data <= rd_mux;
   end

   p_hbuf_snap_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_lo && mode_16) |=> (hbuf == $past(cnt_hi)));
   p_hbuf_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_lo && !wr_hbuf) |=> $stable(hbuf));

endmodule

// File: rtl/shadow_timer.sv
module shadow_timer #(
   parameter int BYTE_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        addr,
   input  logic              wr_stb,
   input  logic              rd_stb,
   input  logic [BYTE_W-1:0] wr_data,
   output logic [BYTE_W-1:0] rd_data,
   input  logic              mode_16,
   input  logic              ext_sel,
   input  logic              int_tick,
   input  logic              ext_clk,
   output logic              irq
);

   logic              ext_rise;
   logic              tick;
   logic [BYTE_W-1:0] cnt_lo;
   logic [BYTE_W-1:0] cnt_hi;
   logic [BYTE_W-1:0] hbuf;
   logic              flag;
   logic              irq_en;
   logic              wr_lo;
   logic              wr_ctrl;

   st_edge_sync #(.STAGES(SYNC_STAGES)) i_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .async_in (ext_clk),
      .rise_o   (ext_rise)
   );

   assign tick = ext_sel ? ext_rise : int_tick;

   st_count_core #(.BYTE_W(BYTE_W)) i_core (
      .clk     (clk),
      .rst_n   (rst_n),
      .mode_16 (mode_16),
      .tick    (tick),
      .wr_lo   (wr_lo),
      .wr_ctrl (wr_ctrl),
      .wdata   (wr_data),
      .hbuf    (hbuf),
      .cnt_lo  (cnt_lo),
      .cnt_hi  (cnt_hi),
      .flag    (flag),
      .irq_en  (irq_en),
      .irq     (irq)
   );

   st_bus_regs #(.BYTE_W(BYTE_W)) i_bus (
      .clk     (clk),
      .rst_n   (rst_n),
      .addr    (addr),
      .wr_stb  (wr_stb),
      .rd_stb  (rd_stb),
      .wr_data (wr_data),
      .mode_16 (mode_16),
      .cnt_lo  (cnt_lo),
      .cnt_hi  (cnt_hi),
      .flag    (flag),
      .irq_en  (irq_en),
      .hbuf    (hbuf),
      .wr_lo   (wr_lo),
      .wr_ctrl (wr_ctrl),
      .rd_data (rd_data)
   );

endmodule

// File: tb/test_shadow_timer.sv
module test_shadow_timer;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] addr = 2'd0;
   logic       wr_stb = 1'b0;
   logic       rd_stb = 1'b0;
   logic [7:0] wr_data = 8'h00;
   logic [7:0] rd_data;
   logic       mode_16 = 1'b1;
   logic       ext_sel = 1'b0;
   logic       int_tick = 1'b0;
   logic       ext_clk = 1'b0;
   logic       irq;

   int checks = 0;
   int errors = 0;
   logic [7:0] exp_q[$];
   string      tag_q[$];
   logic       due = 1'b0;

   always #10 clk = ~clk;

   shadow_timer i_shadow_timer (
      .clk(clk), .rst_n(rst_n), .addr(addr), .wr_stb(wr_stb), .rd_stb(rd_stb),
      .wr_data(wr_data), .rd_data(rd_data), .mode_16(mode_16), .ext_sel(ext_sel),
      .int_tick(int_tick), .ext_clk(ext_clk), .irq(irq)
   );

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   // monitor: compares each registered read result with the queued expectation
   always @(posedge clk) due <= rd_stb;
   always @(negedge clk) begin
      if (due) begin
         if (exp_q.size() == 0) check(1'b0, "scoreboard underflow", rd_data, 0);
         else begin
            logic [7:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(rd_data === e, t, rd_data, e);
         end
      end
   end

   task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
      addr = a; wr_data = d; wr_stb = 1'b1;
      @(negedge clk);
      wr_stb = 1'b0;
   endtask

   task automatic bus_rd(input logic [1:0] a, input logic [7:0] e, input string t);
      addr = a; rd_stb = 1'b1;
      exp_q.push_back(e);
      tag_q.push_back(t);
      @(negedge clk);
      rd_stb = 1'b0;
      @(negedge clk);
   endtask

   task automatic ticks(input int n);
      int_tick = 1'b1;
      repeat (n) @(negedge clk);
      int_tick = 1'b0;
   endtask

   task automatic load16(input logic [7:0] hi, input logic [7:0] lo);
      bus_wr(2'd1, hi);
      bus_wr(2'd0, lo);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog: actual 0x0 expected 0x1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset values, checked before reset is released
      check(irq === 1'b0, "R1 irq", irq, 0);
      check(rd_data === 8'h00, "R1 rd_data", rd_data, 0);
      rst_n = 1'b1;
      @(negedge clk);
      bus_rd(2'd0, 8'h00, "R1 low byte");
      bus_rd(2'd1, 8'h00, "R1 holding");
      bus_rd(2'd2, 8'h00, "R1 control");

      // R2 internal counting and hold
      ticks(5);
      bus_rd(2'd0, 8'h05, "R2 count 5");
      repeat (10) @(negedge clk);
      bus_rd(2'd0, 8'h05, "R2 hold");

      // R7/R8 coherent split read across rollover
      load16(8'h12, 8'hFF);
      bus_rd(2'd0, 8'hFF, "R7 low read");
      ticks(1);
      bus_rd(2'd1, 8'h12, "R8 held byte after rollover");
      bus_rd(2'd0, 8'h00, "R7 low after roll");
      bus_rd(2'd1, 8'h13, "R7 snapshot new high");

      // R9 holding write does not touch counter
      bus_wr(2'd1, 8'h77);
      bus_rd(2'd1, 8'h77, "R9 holding loaded");
      bus_rd(2'd0, 8'h00, "R9 low unchanged");
      bus_rd(2'd1, 8'h13, "R9 high unchanged");

      // R10 write beats tick, then resumes
      bus_wr(2'd1, 8'h00);
      int_tick = 1'b1;
      bus_wr(2'd0, 8'h40);
      int_tick = 1'b0;
      bus_rd(2'd0, 8'h40, "R10 write priority");
      bus_rd(2'd1, 8'h00, "R10 high committed");
      ticks(1);
      bus_rd(2'd0, 8'h41, "R10 resume");

      // R4 16-bit overflow, R6 masked irq
      load16(8'hFF, 8'hFE);
      ticks(1);
      bus_rd(2'd2, 8'h00, "R4 no flag before wrap");
      ticks(1);
      bus_rd(2'd2, 8'h01, "R4 flag on 16-bit wrap");
      check(irq === 1'b0, "R6 masked irq", irq, 0);

      // R5 sticky
      ticks(3);
      bus_rd(2'd2, 8'h01, "R5 flag sticky");

      // R6 enable
      bus_wr(2'd2, 8'h03);
      check(irq === 1'b0, "R6 irq one stage late", irq, 0);
      @(negedge clk);
      check(irq === 1'b1, "R6 irq asserted", irq, 1);

      // R5 clear
      bus_wr(2'd2, 8'h02);
      bus_rd(2'd2, 8'h02, "R5 flag cleared");
      check(irq === 1'b0, "R6 irq drops", irq, 0);

      // R5 collision: clear in the overflow cycle
      load16(8'hFF, 8'hFF);
      int_tick = 1'b1;
      bus_wr(2'd2, 8'h00);
      int_tick = 1'b0;
      bus_rd(2'd2, 8'h01, "R5 overflow wins");
      bus_wr(2'd2, 8'h00);

      // R4/R11 8-bit mode
      mode_16 = 1'b0;
      load16(8'h55, 8'hFE);
      bus_rd(2'd0, 8'hFE, "R11 low loaded");
      bus_rd(2'd1, 8'h00, "R11 high zero");
      ticks(1);
      bus_rd(2'd2, 8'h00, "R4 no 8-bit flag yet");
      ticks(1);
      bus_rd(2'd2, 8'h01, "R4 flag on 8-bit wrap");
      bus_rd(2'd0, 8'h00, "R4 low wrapped");
      bus_rd(2'd1, 8'h00, "R11 high still zero");
      bus_wr(2'd2, 8'h00);

      // R3 external edges, internal tick ignored
      mode_16 = 1'b1;
      load16(8'h00, 8'h00);
      ext_sel = 1'b1;
      int_tick = 1'b1;
      for (int i = 0; i < 5; i++) begin
         ext_clk = 1'b1;
         repeat (3) @(negedge clk);
         ext_clk = 1'b0;
         repeat (3) @(negedge clk);
      end
      ext_clk = 1'b1;
      repeat (20) @(negedge clk);
      ext_clk = 1'b0;
      repeat (5) @(negedge clk);
      int_tick = 1'b0;
      bus_rd(2'd0, 8'h06, "R3 six edges counted once each");
      bus_rd(2'd1, 8'h00, "R3 high zero");

      repeat (3) @(negedge clk);
      check(exp_q.size() == 0, "scoreboard drained", exp_q.size(), 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule